// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block takes one burst request shaped like an address-channel command: a start address, an 8-bit length code, a 3-bit size code and a 2-bit burst type. It then emits the address of every beat of that burst in order, at most one beat per clock, under valid/ready flow control on both sides. It applies the rules for fixed, incrementing and wrapping bursts. A beat is 2^size bytes, and a burst has length code plus one beats.

Before a burst starts, the block checks that the request is legal. A reserved type is rejected. A wrapping burst is rejected when its beat count is not a power of two between 2 and 16, or when its start address is not aligned to the beat size. An incrementing burst is rejected when its byte range would run over a 4 KB page edge. A rejected request produces a one-cycle error pulse with a cause code, and it produces no beats. Downstream logic uses the beat address, the beat index and the last flag to drive its own data path.

Top module: `axb_addr_gen`

## Requirements
- R1: A request is taken on a cycle where req_valid and req_ready are both high. For a legal request, the first beat appears in the following cycle with beat_valid high, beat_idx 0 and beat_addr equal to the start address. Burst type codes are: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved.
- R2: In a fixed burst (type 0), every beat carries the start address.
- R3: In an incrementing burst (type 1), beat k for k≥1 carries floor(start/B)*B + k*B, where B = 2^size. Beat 0 carries the unaligned start address.
- R4: A burst has len+1 beats, indexed 0 to len. beat_last is high only on index len. No beat follows the last one.
- R5: In a wrapping burst, let T = B*(len+1) and L = floor(start/T)*T. Beat k carries L + ((start − L + k*B) mod T).
- R6: A wrapping request whose beat count is not 2, 4, 8 or 16 is rejected with err_code 2.
- R7: A wrapping request with an allowed count but a start address that is not a multiple of B is rejected with err_code 3.
- R8: An incrementing request is rejected with err_code 4 when floor(aligned/4096) differs from floor((aligned + (len+1)*B − 1)/4096). A start of 8184 with B=4 and 3 beats is one such case.
- R9: The reserved type 3 is rejected with err_code 1. This check has priority over every other check.
- R10: req_ready is low while a beat is pending. The only exception is a cycle in which the last beat is handed over (beat_valid, beat_ready and beat_last all high). In that cycle a new request can be taken, and its first beat follows with no gap.
- R11: While beat_valid is high and beat_ready is low, beat_addr, beat_idx and beat_last hold their values.
- R12: A rejected request raises err_valid for exactly the cycle after it is taken, with the cause on err_code and beat_valid low. When err_valid is low, err_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A burst request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_addr | input | ADDR_W | Start address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Downstream takes the presented beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_idx | output | 8 | Index of the current beat, counting from 0 |
| beat_last | output | 1 | The current beat is the final one |
| err_valid | output | 1 | One-cycle pulse for a rejected request |
| err_code | output | 3 | Reject cause: 1 type, 2 wrap count, 3 wrap alignment, 4 page crossing |

## Verification
Handing over the final beat and taking the next request can happen in the same cycle. The bench provokes this by raising a second request while the final beat of a burst is presented with beat_ready held high. It then checks three things: req_ready is high in exactly that cycle, the new burst's first beat (start address, index 0) appears in the next cycle with no idle gap, and a chained request that is illegal instead produces only the error pulse. A sweep over type, size, length and start addresses near wrap windows and page edges compares every beat against arithmetic expectations, with and without downstream stalls.

// File: rtl/axb_pkg.sv
package axb_pkg;

    localparam int LEN_W     = 8;
    localparam int SIZE_W    = 3;
    localparam int PAGE_BITS = 12;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_TYPE   = 3'd1,
        ERR_WLEN   = 3'd2,
        ERR_WALIGN = 3'd3,
        ERR_PAGE   = 3'd4
    } err_e;

    typedef struct packed {
        burst_e              btype;
        logic [SIZE_W-1:0]   size;
        logic [LEN_W-1:0]    len;
    } ctl_t;

    // beat counts allowed for a wrapping burst: 2, 4, 8, 16
    function automatic logic wrap_len_ok(input logic [LEN_W-1:0] len);
        return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    endfunction

endpackage

// File: rtl/axb_check.sv
module axb_check
    import axb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctl_t              ctl,
    output err_e              err
);
    localparam int EW = ADDR_W + 17;

    logic [EW-1:0] addr_w;
    logic [EW-1:0] bmask;
    logic [EW-1:0] aligned;
    logic [EW-1:0] span;
    logic [EW-1:0] end_byte;
    logic          misaligned;
    logic          crosses;

    always_comb begin
        addr_w     = EW'(addr);
        bmask      = (EW'(1) << ctl.size) - EW'(1);
        aligned    = addr_w & ~bmask;
        misaligned = (addr_w & bmask) != '0;
        span       = (EW'(ctl.len) + EW'(1)) << ctl.size;
        end_byte   = aligned + span - EW'(1);
        crosses    = (end_byte >> PAGE_BITS) != (aligned >> PAGE_BITS);
    end

    // priority: type, then wrap count, then wrap alignment, then page edge
    always_comb begin
        err = ERR_NONE;
        unique case (ctl.btype)
            BT_RSVD: err = ERR_TYPE;
            BT_WRAP: begin
                if (!wrap_len_ok(ctl.len))  err = ERR_WLEN;
                else if (misaligned)        err = ERR_WALIGN;
            end
            BT_INCR: if (crosses)           err = ERR_PAGE;
            default: err = ERR_NONE;
        endcase
    end

endmodule

// File: rtl/axb_step.sv
module axb_step
    import axb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  ctl_t              ctl,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] bytes;
    logic [ADDR_W-1:0] bmask;
    logic [ADDR_W-1:0] wmask;

    always_comb begin
        bytes = ADDR_W'(1) << ctl.size;
        bmask = bytes - ADDR_W'(1);
        // window mask: beats*bytes - 1 (only meaningful for legal wrap counts)
        wmask = ((ADDR_W'(ctl.len) + ADDR_W'(1)) << ctl.size) - ADDR_W'(1);
        unique case (ctl.btype)
            BT_FIXED: nxt = cur;
            BT_INCR:  nxt = (cur & ~bmask) + bytes;
            BT_WRAP:  nxt = (cur & ~wmask) | ((cur + bytes) & wmask);
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/axb_addr_gen.sv
module axb_addr_gen
    import axb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_len,
    input  logic [2:0]        req_size,
    input  logic [1:0]        req_burst,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [7:0]        beat_idx,
    output logic              beat_last,
    output logic              err_valid,
    output logic [2:0]        err_code
);
    ctl_t              req_ctl;
    ctl_t              ctl_q;
    err_e              req_err;
    err_e              err_q;
    logic              busy_q;
    logic              errv_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [LEN_W-1:0]  idx_q;
    logic              accept;
    logic              legal;
    logic              at_last;

    always_comb begin
        req_ctl.btype = burst_e'(req_burst);
        req_ctl.size  = req_size;
        req_ctl.len   = req_len;
    end

    axb_check #(.ADDR_W(ADDR_W)) check_i (
        .addr (req_addr),
        .ctl  (req_ctl),
        .err  (req_err)
    );

    axb_step #(.ADDR_W(ADDR_W)) step_i (
        .cur  (addr_q),
        .ctl  (ctl_q),
        .nxt  (addr_nxt)
    );

    assign at_last   = idx_q == ctl_q.len;
    assign req_ready = !busy_q || (beat_ready && at_last);
    assign accept    = req_valid && req_ready;
    assign legal     = req_err == ERR_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            errv_q <= 1'b0;
            err_q  <= ERR_NONE;
            addr_q <= '0;
            idx_q  <= '0;
            ctl_q  <= '{btype: BT_FIXED, size: '0, len: '0};
        end else begin
            errv_q <= accept && !legal;
            err_q  <= (accept && !legal) ? req_err : ERR_NONE;
            if (accept && legal) begin
                busy_q <= 1'b1;
                addr_q <= req_addr;
                idx_q  <= '0;
                ctl_q  <= req_ctl;
            end else if (busy_q && beat_ready) begin
                if (at_last) begin
                    busy_q <= 1'b0;
                end else begin
                    addr_q <= addr_nxt;
                    idx_q  <= idx_q + 8'd1;
                end
            end
        end
    end

    assign beat_valid = busy_q;
    assign beat_addr  = addr_q;
    assign beat_idx   = idx_q;
    assign beat_last  = busy_q && at_last;
    assign err_valid  = errv_q;
    assign err_code   = err_q;

    // R1: a legal request shows up as beat 0 at its start address
    p_first_beat_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && legal) |=> (beat_valid && beat_idx == 8'd0 && beat_addr == $past(req_addr)));

    // R2: fixed bursts never move the address
    p_fixed_same_r2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last && ctl_q.btype == BT_FIXED) |=> $stable(beat_addr));

    // R4: the index advances by one per handed-over beat
    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last) |=> (beat_valid && beat_idx == $past(beat_idx) + 8'd1));

    // R10: no new request while a beat is pending, except on the final handover
    p_busy_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !(beat_ready && beat_last)) |-> !req_ready);

    // R11: a stalled beat holds
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_idx)));

    // R12: an error pulse never coexists with a beat
    p_err_nobeat_r12: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (!beat_valid && err_code != 3'd0));

endmodule

// File: tb/axb_addr_gen_tb_top.sv
module axb_addr_gen_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_len = '0;
    logic [2:0]    req_size = '0;
    logic [1:0]    req_burst = '0;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [AW-1:0] beat_addr;
    logic [7:0]    beat_idx;
    logic          beat_last;
    logic          err_valid;
    logic [2:0]    err_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    axb_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_idx(beat_idx), .beat_last(beat_last),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_err(int a, int len, int sz, int bt);
        int b = 1 << sz;
        int al = (a / b) * b;
        if (bt == 3) return 1;
        if (bt == 2) begin
            if (!(len == 1 || len == 3 || len == 7 || len == 15)) return 2;
            if (a % b != 0) return 3;
        end
        if (bt == 1 && (al / 4096) != ((al + (len + 1) * b - 1) / 4096)) return 4;
        return 0;
    endfunction

    function automatic int exp_addr(int a, int len, int sz, int bt, int k);
        int b = 1 << sz;
        int t = b * (len + 1);
        int lo = (a / t) * t;
        if (bt == 0) return a;
        if (bt == 1) return (k == 0) ? a : (a / b) * b + k * b;
        return lo + ((a - lo + k * b) % t);
    endfunction

    function automatic string mode_tag(int bt);
        if (bt == 0) return "R2";
        if (bt == 1) return "R3";
        return "R5";
    endfunction

    function automatic string err_tag(int e);
        case (e)
            1: return "R9";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    // present beats of a running burst; optional chained request on final beat
    task automatic drain(int a, int len, int sz, int bt, int sm,
                         bit chain, int ca, int clen, int csz, int cbt);
        int k = 0;
        int cyc = 0;
        bit rdy;
        while (k <= len) begin
            rdy = (sm == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (chain && k == len) begin
                rdy = 1'b1;
                req_addr = AW'(ca); req_len = 8'(clen); req_size = 3'(csz);
                req_burst = 2'(cbt); req_valid = 1'b1;
            end
            beat_ready = rdy;
            #1;
            chk(beat_valid && int'(beat_addr) == exp_addr(a, len, sz, bt, k),
                rdy ? mode_tag(bt) : "R11 stall", int'(beat_addr), exp_addr(a, len, sz, bt, k));
            chk(int'(beat_idx) == k && beat_last == (k == len), "R4 index/last",
                int'(beat_idx), k);
            chk(req_ready == (rdy && k == len), "R10 ready", int'(req_ready), int'(rdy && k == len));
            @(negedge clk);
            cyc++;
            if (rdy) k++;
        end
        req_valid = 1'b0;
        beat_ready = 1'b0;
        #1;
        if (!chain) begin
            chk(!beat_valid && req_ready, "R4 no extra beat", int'(beat_valid), 0);
        end else if (exp_err(ca, clen, csz, cbt) != 0) begin
            chk(err_valid && int'(err_code) == exp_err(ca, clen, csz, cbt) && !beat_valid,
                "R10 chained reject", int'(err_code), exp_err(ca, clen, csz, cbt));
        end else begin
            chk(beat_valid && int'(beat_addr) == ca && beat_idx == 8'd0,
                "R10 back-to-back first beat", int'(beat_addr), ca);
            @(negedge clk);
            // first beat was already seen once; re-enter drain from it
            drain(ca, clen, csz, cbt, 0, 1'b0, 0, 0, 0, 0);
        end
    endtask

    task automatic run_req(int a, int len, int sz, int bt, int sm);
        int e = exp_err(a, len, sz, bt);
        @(negedge clk);
        req_addr = AW'(a); req_len = 8'(len); req_size = 3'(sz); req_burst = 2'(bt);
        req_valid = 1'b1;
        beat_ready = 1'b0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (e != 0) begin
            #1;
            chk(err_valid && int'(err_code) == e && !beat_valid, err_tag(e), int'(err_code), e);
            @(negedge clk);
            #1;
            chk(!err_valid && err_code == 3'd0 && !beat_valid, "R12 single pulse",
                int'(err_valid), 0);
        end else begin
            chk(1'b1, "R1 accepted", 0, 0);
            drain(a, len, sz, bt, sm, 1'b0, 0, 0, 0, 0);
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
                done = 1'b1;
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        int addrs[6] = '{0, 'h35, 'h30, 'hFF0, 8184, 'h1FFD};
        int lens[6]  = '{0, 1, 2, 3, 7, 15};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!beat_valid && req_ready && !err_valid && err_code == 3'd0, "R1 reset state",
            int'(beat_valid), 0);

        for (int bt = 0; bt < 4; bt++)
            for (int sz = 0; sz < 4; sz++)
                for (int li = 0; li < 6; li++)
                    for (int ai = 0; ai < 6; ai++)
                        run_req(addrs[ai], lens[li], sz, bt, (ai + li) % 2);

        // long bursts
        run_req(0, 255, 0, 1, 1);
        run_req('h0F05, 255, 0, 1, 0);   // R8 page crossing
        run_req('h0123, 255, 2, 0, 0);   // R2 fixed, 256 beats
        run_req(8184, 2, 2, 1, 0);       // R8 example

        // R10 back-to-back: legal chain, then illegal chain
        @(negedge clk);
        req_addr = AW'('h100); req_len = 8'd3; req_size = 3'd2; req_burst = 2'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain('h100, 3, 2, 1, 1, 1'b1, 'h38, 3, 2, 2);
        @(negedge clk);
        req_addr = AW'('h200); req_len = 8'd1; req_size = 3'd1; req_burst = 2'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        drain('h200, 1, 1, 2, 0, 1'b1, 'h40, 2, 0, 3);
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule